// File: doc/BRIEF.md
# Address Cycle Selector for 64-bit Bus Transfers

This block produces the address phase of every bus-master transfer that an instruction-driven DMA engine issues. It keeps six upper-dword selector registers. Five are static: software, load/store or memory-move instructions write them through a register write port. The sixth is dynamic. It is loaded from the block-move fetch and only direct block moves read it.

For each request, the instruction class picks one selector. When the selected upper dword is zero, the block emits a single address cycle (SAC): one phase that carries the real command. When it is nonzero, the block emits a dual address cycle (DAC): one phase with the lower dword and the dual-address command, then one phase with the upper dword and the real command.

A request whose byte span would pass the 4 GB line of its lower address is refused. The block raises an error pulse and emits no address phase. The requester holds the request stable until `done` pulses.

Top module: `addr_cycle_sel`

## Requirements
- R1: After reset every selector is zero, so each class (0 to 6) yields a SAC: one phase with `ap_addr` equal to `req_addr`, `ap_cbe` equal to `req_cmd`, and `done` high in that same cycle.
- R2: The `req_cls` encoding selects a selector as follows:
  - 0, direct block move: dynamic selector.
  - 1, table-indirect block move: static selector 0.
  - 2, indirect block move: static selector 1.
  - 3, memory-move source: static selector 2.
  - 4, memory-move destination: static selector 3.
  - 5, load/store: static selector 4.
  - 6, jump: static selector 4.
- R3: A write with `wr_idx` 0 to 4 loads static selector `wr_idx` from `wr_data`. A write with `wr_idx` 5, 6 or 7 changes no selector.
- R4: Only `dyn_ld` changes the dynamic selector. It loads `dyn_data`.
- R5: A nonzero selected dword yields a DAC. The first phase has `ap_addr`=`req_addr`, `ap_cbe`=4'b1101 and `done` low. The next cycle has `ap_addr` equal to the selector value, `ap_cbe`=`req_cmd` and `done` high.
- R6: If `req_addr + req_len` exceeds 2^32, the block asserts `err` and `done` for one cycle and `ap_valid` stays low. A span that ends exactly at 2^32 is accepted, and a zero length never crosses.
- R7: Class 7 is reserved. A request with class 7 is refused in the same way as in R6.
- R8: Handshake timing:
  - The first phase, or the error, appears in the cycle after the clock edge that sees `req_valid` while the block is idle.
  - `done` is a one-cycle pulse.
  - The block issues no phase without a request.
  - In the cycle after `done`, all outputs are quiet.
- R9: Writing zero back to a selector makes its classes return to SAC.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Static selector write strobe |
| wr_idx | input | 3 | Static selector index |
| wr_data | input | 32 | Value written to a static selector |
| dyn_ld | input | 1 | Dynamic selector load strobe |
| dyn_data | input | 32 | Value loaded into the dynamic selector |
| req_valid | input | 1 | Request present, held until done |
| req_cls | input | 3 | Instruction class |
| req_addr | input | 32 | Lower address dword |
| req_len | input | 24 | Byte count |
| req_cmd | input | 4 | Transfer command code |
| ap_valid | output | 1 | Address phase present |
| ap_addr | output | 32 | Address driven in this phase |
| ap_cbe | output | 4 | Command driven in this phase |
| done | output | 1 | Last phase or refusal of the request |
| err | output | 1 | Request refused |

## Verification
The assertions check on every cycle the shape of the output sequence:
- A refusal never carries a phase, and `done` never lasts two cycles.
- A phase without `done` always carries the dual-address code and is followed by a closing phase.
- No phase starts without a request.

Only the bench's scenarios can show the values themselves. These are the class-to-selector table, which upper dword appears in the second phase, the exact 4 GB boundary, and that writes to indices 5 to 7 change nothing.

// File: rtl/addr_cycle_sel.sv
module addr_cycle_sel #(
  parameter int AW    = 32,
  parameter int LW    = 24,
  parameter int NSTAT = 5
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr_en,
  input  logic [$clog2(NSTAT+1)-1:0]   wr_idx,
  input  logic [AW-1:0]                wr_data,
  input  logic                         dyn_ld,
  input  logic [AW-1:0]                dyn_data,
  input  logic                         req_valid,
  input  logic [2:0]                   req_cls,
  input  logic [AW-1:0]                req_addr,
  input  logic [LW-1:0]                req_len,
  input  logic [3:0]                   req_cmd,
  output logic                         ap_valid,
  output logic [AW-1:0]                ap_addr,
  output logic [3:0]                   ap_cbe,
  output logic                         done,
  output logic                         err
);
  localparam int IW = $clog2(NSTAT+1);
  localparam logic [IW-1:0] DYN = IW'(NSTAT);
  localparam logic [3:0] DAC_CMD = 4'b1101;

  typedef enum logic [1:0] {IDLE, DAC_LO, LAST, FAIL} st_t;

  logic [AW-1:0] sel_q [NSTAT+1];
  st_t           st;
  logic [AW-1:0] lo_q, hi_q;
  logic [3:0]    cmd_q;
  logic          dac_q;

  logic [IW-1:0] pick;
  logic          bad_cls;
  always_comb begin
    bad_cls = 1'b0;
    case (req_cls)
      3'd0:    pick = DYN;
      3'd1:    pick = IW'(0);
      3'd2:    pick = IW'(1);
      3'd3:    pick = IW'(2);
      3'd4:    pick = IW'(3);
      3'd5,
      3'd6:    pick = IW'(4);
      default: begin pick = IW'(0); bad_cls = 1'b1; end
    endcase
  end

  wire [AW-1:0] hi_sel    = sel_q[pick];
  wire [AW:0]   span_end  = {1'b0, req_addr} + (AW+1)'(req_len);
  wire          crosses   = span_end > {1'b1, {AW{1'b0}}};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i <= NSTAT; i++) sel_q[i] <= '0;
    end else begin
      if (wr_en && wr_idx < DYN) sel_q[wr_idx] <= wr_data;
      if (dyn_ld) sel_q[NSTAT] <= dyn_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st    <= IDLE;
      lo_q  <= '0;
      hi_q  <= '0;
      cmd_q <= '0;
      dac_q <= 1'b0;
    end else begin
      case (st)
        IDLE: if (req_valid) begin
          lo_q  <= req_addr;
          hi_q  <= hi_sel;
          cmd_q <= req_cmd;
          dac_q <= hi_sel != '0;
          if (crosses || bad_cls) st <= FAIL;
          else if (hi_sel != '0)  st <= DAC_LO;
          else                    st <= LAST;
        end
        DAC_LO:  st <= LAST;
        default: st <= IDLE;
      endcase
    end
  end

  assign ap_valid = (st == DAC_LO) || (st == LAST);
  assign ap_addr  = (st == LAST && dac_q) ? hi_q : lo_q;
  assign ap_cbe   = (st == DAC_LO) ? DAC_CMD : cmd_q;
  assign done     = (st == LAST) || (st == FAIL);
  assign err      = (st == FAIL);
endmodule

// File: rtl/addr_cycle_sel_chk.sv
module addr_cycle_sel_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       req_valid,
  input logic       ap_valid,
  input logic [3:0] ap_cbe,
  input logic       done,
  input logic       err
);
  p_err_no_phase_r6: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> done && !ap_valid);

  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_dac_code_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ap_valid && !done |-> ap_cbe == 4'b1101);

  p_dac_second_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ap_valid && !done |=> ap_valid && done);

  p_phase_needs_req_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ap_valid) |-> $past(req_valid));
endmodule

bind addr_cycle_sel addr_cycle_sel_chk chk_i (
  .clk, .rst_n, .req_valid, .ap_valid, .ap_cbe, .done, .err
);

// File: tb/addr_cycle_sel_tb_top.sv
module addr_cycle_sel_tb_top;
  logic        clk = 0, rst_n = 0;
  logic        wr_en = 0, dyn_ld = 0, req_valid = 0;
  logic [2:0]  wr_idx = 0, req_cls = 0;
  logic [31:0] wr_data = 0, dyn_data = 0, req_addr = 0;
  logic [23:0] req_len = 0;
  logic [3:0]  req_cmd = 0;
  logic        ap_valid, done, err;
  logic [31:0] ap_addr;
  logic [3:0]  ap_cbe;
  int checks = 0, fails = 0, cyc = 0;

  always #10 clk = ~clk;

  addr_cycle_sel dut_i (.*);

  typedef struct packed {
    logic [2:0]  cls;
    logic [31:0] addr;
    logic [23:0] len;
    logic [3:0]  cmd;
    logic [1:0]  nph;
    logic [31:0] hi;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VEC [NV] = '{
    '{3'd1, 32'h0000_1000, 24'd16, 4'h6, 2'd2, 32'h11},
    '{3'd2, 32'h0000_2000, 24'd64, 4'h7, 2'd2, 32'h22},
    '{3'd3, 32'h0000_3000, 24'd4,  4'h6, 2'd2, 32'h33},
    '{3'd4, 32'h0000_4000, 24'd8,  4'h7, 2'd1, 32'h0},
    '{3'd5, 32'h0000_5000, 24'd4,  4'h6, 2'd2, 32'h55},
    '{3'd6, 32'h0000_6000, 24'd4,  4'h6, 2'd2, 32'h55},
    '{3'd0, 32'h0000_7000, 24'd32, 4'h7, 2'd2, 32'hA0A0_0001},
    '{3'd1, 32'hFFFF_FFF0, 24'd16, 4'h6, 2'd2, 32'h11},
    '{3'd1, 32'hFFFF_FFF0, 24'd17, 4'h6, 2'd0, 32'h0},
    '{3'd7, 32'h0000_0100, 24'd4,  4'h6, 2'd0, 32'h0},
    '{3'd5, 32'hFFFF_FFFF, 24'd0,  4'h6, 2'd2, 32'h55},
    '{3'd2, 32'hFFFF_FFFF, 24'd1,  4'h7, 2'd2, 32'h22},
    '{3'd2, 32'hFFFF_FFFF, 24'd2,  4'h7, 2'd0, 32'h0}
  };

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr_sel(input logic [2:0] idx, input logic [31:0] v);
    @(negedge clk); wr_en = 1; wr_idx = idx; wr_data = v;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic run(input vec_t v, input string req);
    @(negedge clk);
    req_valid = 1; req_cls = v.cls; req_addr = v.addr; req_len = v.len; req_cmd = v.cmd;
    @(negedge clk);
    if (v.nph == 0) begin
      chk(err && done && !ap_valid, req, {29'd0, err, done, ap_valid}, 32'h6);
    end else if (v.nph == 1) begin
      chk(ap_valid && done && !err, req, {29'd0, ap_valid, done, err}, 32'h6);
      chk(ap_addr == v.addr && ap_cbe == v.cmd, req, ap_addr, v.addr);
    end else begin
      chk(ap_valid && !done && ap_addr == v.addr && ap_cbe == 4'b1101, req, ap_addr, v.addr);
      @(negedge clk);
      chk(ap_valid && done && ap_cbe == v.cmd, req, {28'd0, ap_cbe}, {28'd0, v.cmd});
      chk(ap_addr == v.hi, req, ap_addr, v.hi);
    end
    req_valid = 0;
    @(negedge clk);
    chk(!ap_valid && !done && !err, {req, " R8 quiet"}, {29'd0, ap_valid, done, err}, 32'h0);
  endtask

  initial begin
    forever begin
      @(posedge clk); cyc++;
      if (cyc > 20000) begin
        fails++;
        $display("FAIL watchdog: actual %0d expected < 20000", cyc);
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!ap_valid && !done && !err, "R1 reset outputs", {29'd0, ap_valid, done, err}, 32'h0);
    rst_n = 1;
    for (int c = 0; c < 7; c++)
      run('{3'(c), 32'h100 * (c + 1), 24'd4, 4'h6, 2'd1, 32'h0}, "R1 reset SAC");
    // R3: indices 5..7 ignored; R4: dynamic only through dyn_ld
    wr_sel(3'd5, 32'hDEAD_BEEF);
    wr_sel(3'd7, 32'h1234_5678);
    run('{3'd0, 32'h800, 24'd4, 4'h7, 2'd1, 32'h0}, "R3 R4 idx5 ignored");
    run('{3'd1, 32'h900, 24'd4, 4'h7, 2'd1, 32'h0}, "R3 idx7 ignored");
    wr_sel(3'd0, 32'h11);
    wr_sel(3'd1, 32'h22);
    wr_sel(3'd2, 32'h33);
    wr_sel(3'd4, 32'h55);
    @(negedge clk); dyn_ld = 1; dyn_data = 32'hA0A0_0001;
    @(negedge clk); dyn_ld = 0;
    for (int i = 0; i < NV; i++)
      run(VEC[i], "R2 R5 R6 R7 table");
    wr_sel(3'd0, 32'h0);
    run('{3'd1, 32'hA00, 24'd4, 4'h6, 2'd1, 32'h0}, "R9 back to SAC");
    run('{3'd2, 32'hB00, 24'd4, 4'h6, 2'd2, 32'h22}, "R9 other kept");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule